// File: doc/BRIEF.md
# Accelerator L1 Coherence Line Controller

This block keeps the coherence state of a small private, direct-mapped accelerator cache that talks to the host only through a reduced message set. Each line is in one of five states: invalid, shared, exclusive, modified, or pending. The pending state covers both a fill in flight and a writeback in flight. Local loads and stores that miss send a read-for-share or a read-for-ownership request. The fill message that comes back decides the state the line is installed in.

Host invalidations are answered according to how the line is held. Conflict misses first send a release message for the victim line. That line stays blocked until the host acknowledges the writeback. Only one transaction can be outstanding per line, and local requests to a busy line are refused. No acknowledgements are counted and no races are resolved here. The host-side translator is trusted to deliver only well-formed responses. Messages that do not fit the current line state are dropped.

Top module: `l1c_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, and no outgoing message or completion is presented.
- R2: A load that finds its line invalid is accepted and sends a share request (out code 0) for the request address one cycle later. A store in the same situation sends an ownership request (out code 1). The line becomes pending.
- R3: A fill (in code 0 = shared, 1 = exclusive, 2 = modified) whose address matches a line pending on a fill installs the line in that state. A completion pulse carrying the fill address appears one cycle later.
- R4: An invalidate (in code 4) that hits a modified line is answered with a dirty writeback (out code 7). One that hits an exclusive line gets a clean writeback (out code 6). Any other valid line, or a miss, gets an invalidate ack (out code 5). A hit line becomes invalid. The reply carries the invalidate address one cycle later.
- R5: A request to a valid line with a different tag is refused. It sends a release for the victim address, chosen by the victim's state: shared gives out code 2, exclusive gives 3, modified gives 4. The line stays pending until a writeback ack (in code 3) for that address arrives, and then becomes invalid.
- R6: A load hit on shared, exclusive or modified, and a store hit on exclusive or modified, give a completion one cycle later and send no message. A store hit on exclusive moves the line to modified without any message.
- R7: A store that hits a shared line is accepted and sends an ownership request (out code 1) for that address. The line becomes pending until a fill arrives.
- R8: An invalidate to a pending line is answered with an invalidate ack, and the line stays pending.
- R9: The local request ready is low whenever a host message is presented or the target line is pending.
- R10: A fill to a line not pending on a fill with that tag, and a writeback ack to a line not pending on a writeback with that tag, change nothing and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | TAG_W+log2(NLINES) | Line address, index in the low bits |
| req_ready | output | 1 | Request accepted this cycle |
| host_valid | input | 1 | Host message present |
| host_type | input | 3 | Host message code |
| host_addr | input | TAG_W+log2(NLINES) | Host message line address |
| out_valid | output | 1 | Outgoing message present |
| out_type | output | 3 | Outgoing message code |
| out_addr | output | TAG_W+log2(NLINES) | Outgoing message line address |
| done_valid | output | 1 | Local request completed |
| done_addr | output | TAG_W+log2(NLINES) | Address of the completed request |

## Verification
The assertions assume that the host sends a fill only for an outstanding request, and that the fill kind suits that request. They also assume a writeback ack arrives only after a release, and that every outgoing message is consumed in the cycle it is presented. The stimulus answers pending lines only from the reference model's record of what each line waits for. Store misses are filled as modified and load misses as shared or exclusive. Invalidates go to arbitrary addresses at any time. Stray fills and stray acks are also injected on purpose; the controller must drop them and the checks confirm that it does.

// File: rtl/l1c_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the accelerator L1 coherence controller.
package l1c_pkg;
    typedef enum logic [2:0] {
        LS_I = 3'd0, LS_S = 3'd1, LS_E = 3'd2, LS_M = 3'd3, LS_P = 3'd4
    } line_st_t;

    typedef enum logic [2:0] {
        OM_GETS = 3'd0, OM_GETM = 3'd1, OM_PUTS = 3'd2, OM_PUTE = 3'd3,
        OM_PUTM = 3'd4, OM_INVACK = 3'd5, OM_CLEANWB = 3'd6, OM_DIRTYWB = 3'd7
    } out_msg_t;

    typedef enum logic [2:0] {
        IM_DATAS = 3'd0, IM_DATAE = 3'd1, IM_DATAM = 3'd2,
        IM_WBACK = 3'd3, IM_INV = 3'd4, IM_RSV5 = 3'd5, IM_RSV6 = 3'd6, IM_RSV7 = 3'd7
    } in_msg_t;
endpackage

// File: rtl/l1c_line_store.sv
`timescale 1ns/1ps
// Per-line state, tag and writeback flag for a direct-mapped array.
// Two combinational read ports, one write port.
// Assumes NLINES is a power of two.
module l1c_line_store
    import l1c_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int TAG_W  = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_t         rd_a_st,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic             rd_a_pwb,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_t         rd_b_st,
    output logic [TAG_W-1:0] rd_b_tag,
    output logic             rd_b_pwb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_t         wr_st,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_pwb
);
    line_st_t         st_q  [NLINES];
    logic [TAG_W-1:0] tag_q [NLINES];
    logic             pwb_q [NLINES];

    // Clear every line on reset, else apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= LS_I;
                tag_q[i] <= '0;
                pwb_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]  <= wr_st;
            tag_q[wr_idx] <= wr_tag;
            pwb_q[wr_idx] <= wr_pwb;
        end
    end

    // Read ports.
    always_comb begin
        rd_a_st  = st_q[rd_a_idx];
        rd_a_tag = tag_q[rd_a_idx];
        rd_a_pwb = pwb_q[rd_a_idx];
        rd_b_st  = st_q[rd_b_idx];
        rd_b_tag = tag_q[rd_b_idx];
        rd_b_pwb = pwb_q[rd_b_idx];
    end
endmodule

// File: rtl/l1c_decide.sv
`timescale 1ns/1ps
// Transition logic: host messages take priority over local requests.
// Produces the line update, the next outgoing message and the completion.
// Assumes the host sends only well-formed responses; stray ones are dropped.
module l1c_decide
    import l1c_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int TAG_W  = 8,
    localparam int IDX_W = $clog2(NLINES),
    localparam int AW    = TAG_W + IDX_W
) (
    input  logic             in_valid,
    input  in_msg_t          in_type,
    input  logic [AW-1:0]    in_addr,
    input  line_st_t         h_st,
    input  logic [TAG_W-1:0] h_tag,
    input  logic             h_pwb,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [AW-1:0]    req_addr,
    input  line_st_t         r_st,
    input  logic [TAG_W-1:0] r_tag,
    output logic             req_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_st_t         wr_st,
    output logic [TAG_W-1:0] wr_tag,
    output logic             wr_pwb,
    output logic             msg_v,
    output out_msg_t         msg_t,
    output logic [AW-1:0]    msg_addr,
    output logic             done_v,
    output logic [AW-1:0]    done_addr
);
    logic h_hit, r_hit;
    assign h_hit = (h_tag == in_addr[AW-1:IDX_W]);
    assign r_hit = (r_tag == req_addr[AW-1:IDX_W]);

    // Select the single transition taken this cycle.
    always_comb begin
        req_ready = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = req_addr[IDX_W-1:0];
        wr_st     = LS_I;
        wr_tag    = req_addr[AW-1:IDX_W];
        wr_pwb    = 1'b0;
        msg_v     = 1'b0;
        msg_t     = OM_GETS;
        msg_addr  = req_addr;
        done_v    = 1'b0;
        done_addr = req_addr;
        if (in_valid) begin
            wr_idx   = in_addr[IDX_W-1:0];
            wr_tag   = h_tag;
            msg_addr = in_addr;
            case (in_type)
                IM_DATAS, IM_DATAE, IM_DATAM: begin
                    if (h_st == LS_P && !h_pwb && h_hit) begin
                        wr_en     = 1'b1;
                        wr_st     = (in_type == IM_DATAS) ? LS_S :
                                    (in_type == IM_DATAE) ? LS_E : LS_M;
                        done_v    = 1'b1;
                        done_addr = in_addr;
                    end
                end
                IM_WBACK: begin
                    if (h_st == LS_P && h_pwb && h_hit) wr_en = 1'b1;
                end
                IM_INV: begin
                    msg_v = 1'b1;
                    msg_t = OM_INVACK;
                    if (h_hit) begin
                        case (h_st)
                            LS_M: begin msg_t = OM_DIRTYWB; wr_en = 1'b1; end
                            LS_E: begin msg_t = OM_CLEANWB; wr_en = 1'b1; end
                            LS_S: wr_en = 1'b1;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end else if (req_valid) begin
            case (r_st)
                LS_P: ;
                LS_I: begin
                    req_ready = 1'b1;
                    wr_en     = 1'b1;
                    wr_st     = LS_P;
                    msg_v     = 1'b1;
                    msg_t     = req_store ? OM_GETM : OM_GETS;
                end
                default: begin
                    if (!r_hit) begin
                        wr_en    = 1'b1;
                        wr_st    = LS_P;
                        wr_tag   = r_tag;
                        wr_pwb   = 1'b1;
                        msg_v    = 1'b1;
                        msg_t    = (r_st == LS_S) ? OM_PUTS :
                                   (r_st == LS_E) ? OM_PUTE : OM_PUTM;
                        msg_addr = {r_tag, req_addr[IDX_W-1:0]};
                    end else if (req_store && r_st == LS_S) begin
                        req_ready = 1'b1;
                        wr_en     = 1'b1;
                        wr_st     = LS_P;
                        msg_v     = 1'b1;
                        msg_t     = OM_GETM;
                    end else begin
                        req_ready = 1'b1;
                        done_v    = 1'b1;
                        if (req_store && r_st == LS_E) begin
                            wr_en = 1'b1;
                            wr_st = LS_M;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/l1c_coh_ctrl.sv
`timescale 1ns/1ps
// Top: coherence controller for a private direct-mapped accelerator L1.
// Outgoing messages and completions are registered (one cycle latency).
// Assumes every outgoing message is consumed in the cycle it is shown.
module l1c_coh_ctrl
    import l1c_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int TAG_W  = 8,
    localparam int IDX_W = $clog2(NLINES),
    localparam int AW    = TAG_W + IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_store,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    input  logic          host_valid,
    input  logic [2:0]    host_type,
    input  logic [AW-1:0] host_addr,
    output logic          out_valid,
    output logic [2:0]    out_type,
    output logic [AW-1:0] out_addr,
    output logic          done_valid,
    output logic [AW-1:0] done_addr
);
    line_st_t         h_st, r_st, wr_st;
    logic [TAG_W-1:0] h_tag, r_tag, wr_tag;
    logic             h_pwb, r_pwb, wr_pwb, wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             msg_v, done_v;
    out_msg_t         msg_t;
    logic [AW-1:0]    msg_addr, d_addr;

    l1c_line_store #(.NLINES(NLINES), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(host_addr[IDX_W-1:0]), .rd_a_st(h_st), .rd_a_tag(h_tag), .rd_a_pwb(h_pwb),
        .rd_b_idx(req_addr[IDX_W-1:0]),  .rd_b_st(r_st), .rd_b_tag(r_tag), .rd_b_pwb(r_pwb),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_pwb(wr_pwb)
    );

    l1c_decide #(.NLINES(NLINES), .TAG_W(TAG_W)) decide_i (
        .in_valid(host_valid), .in_type(in_msg_t'(host_type)), .in_addr(host_addr),
        .h_st(h_st), .h_tag(h_tag), .h_pwb(h_pwb),
        .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
        .r_st(r_st), .r_tag(r_tag), .req_ready(req_ready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_pwb(wr_pwb),
        .msg_v(msg_v), .msg_t(msg_t), .msg_addr(msg_addr),
        .done_v(done_v), .done_addr(d_addr)
    );

    // Register the outgoing message and the completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_type   <= 3'd0;
            out_addr   <= '0;
            done_valid <= 1'b0;
            done_addr  <= '0;
        end else begin
            out_valid  <= msg_v;
            out_type   <= msg_t;
            out_addr   <= msg_addr;
            done_valid <= done_v;
            done_addr  <= d_addr;
        end
    end

    // The request-side write-back flag is not needed by the transition logic.
    logic unused_ok;
    assign unused_ok = r_pwb;

    p_gets_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == OM_GETS) |-> $past(req_valid && req_ready && !req_store));
    p_getm_from_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == OM_GETM) |-> $past(req_valid && req_ready && req_store));
    p_put_on_refusal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type inside {OM_PUTS, OM_PUTE, OM_PUTM})
            |-> $past(req_valid && !req_ready && !host_valid));
    p_inv_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type inside {OM_INVACK, OM_CLEANWB, OM_DIRTYWB})
            |-> $past(host_valid && host_type == IM_INV));
    p_done_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(req_valid && req_ready) ||
                        $past(host_valid && host_type inside {IM_DATAS, IM_DATAE, IM_DATAM})));
    p_done_no_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && out_valid));
    p_host_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> !req_ready);
endmodule

// File: tb/l1c_coh_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural line model compared with the design every clock.
module l1c_coh_ctrl_tb_top;
    localparam int NL = 8;
    localparam int TW = 2;
    localparam int AW = 5;
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_store = 1'b0, host_valid = 1'b0;
    logic [AW-1:0] req_addr = '0, host_addr = '0;
    logic [2:0] host_type = 3'd0;
    logic req_ready, out_valid, done_valid;
    logic [2:0] out_type;
    logic [AW-1:0] out_addr, done_addr;

    always #4 clk = ~clk;

    l1c_coh_ctrl #(.NLINES(NL), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_ready(req_ready), .host_valid(host_valid),
        .host_type(host_type), .host_addr(host_addr), .out_valid(out_valid),
        .out_type(out_type), .out_addr(out_addr), .done_valid(done_valid),
        .done_addr(done_addr)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    // model: 0 I, 1 S, 2 E, 3 M, 4 pending
    int m_st[NL], m_tag[NL];
    bit m_pst[NL], m_pwb[NL];
    bit e_ov, e_dv, e_rdy;
    int e_ot, e_oa, e_da;
    string e_to, e_td;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(bit hv, int ht, int ha, bit rv, bit rs, int ra);
        int i, t;
        e_ov = 0; e_dv = 0; e_rdy = 0; e_to = "R2"; e_td = "R6";
        if (hv) begin
            i = ha % NL; t = ha / NL;
            if (ht <= 2) begin
                if (m_st[i] == 4 && !m_pwb[i] && m_tag[i] == t) begin
                    m_st[i] = ht + 1; e_dv = 1; e_da = ha; e_td = "R3";
                end else begin e_td = "R10"; end
                e_to = "R10";
            end else if (ht == 3) begin
                if (m_st[i] == 4 && m_pwb[i] && m_tag[i] == t) begin m_st[i] = 0; e_to = "R5"; end
                else e_to = "R10";
                e_td = "R10";
            end else begin
                e_ov = 1; e_oa = ha; e_ot = 5; e_to = (m_st[i] == 4) ? "R8" : "R4";
                if (m_tag[i] == t) begin
                    if (m_st[i] == 3) begin e_ot = 7; m_st[i] = 0; end
                    else if (m_st[i] == 2) begin e_ot = 6; m_st[i] = 0; end
                    else if (m_st[i] == 1) m_st[i] = 0;
                end
            end
        end else if (rv) begin
            i = ra % NL; t = ra / NL;
            if (m_st[i] == 4) begin
                e_to = "R9";
            end else if (m_st[i] == 0) begin
                e_rdy = 1; e_ov = 1; e_ot = rs ? 1 : 0; e_oa = ra;
                m_st[i] = 4; m_tag[i] = t; m_pst[i] = rs; m_pwb[i] = 0;
            end else if (m_tag[i] != t) begin
                e_to = "R5"; e_ov = 1; e_oa = m_tag[i] * NL + i;
                e_ot = (m_st[i] == 1) ? 2 : (m_st[i] == 2) ? 3 : 4;
                m_st[i] = 4; m_pwb[i] = 1;
            end else if (rs && m_st[i] == 1) begin
                e_to = "R7"; e_rdy = 1; e_ov = 1; e_ot = 1; e_oa = ra;
                m_st[i] = 4; m_pst[i] = 1; m_pwb[i] = 0;
            end else begin
                e_to = "R6"; e_rdy = 1; e_dv = 1; e_da = ra;
                if (rs && m_st[i] == 2) m_st[i] = 3;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_pst[i] = 0; m_pwb[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "done_valid after reset", int'(done_valid), 0);
        e_ov = 0; e_dv = 0; e_to = "R1"; e_td = "R1";
        for (int c = 0; c < NCYC; c++) begin
            bit hv, rv, rs;
            int ht, ha, ra, r, pick;
            if (c > 0) begin
                @(negedge clk);
                chk(e_to, "out_valid", int'(out_valid), int'(e_ov));
                if (e_ov) begin
                    chk(e_to, "out_type", int'(out_type), e_ot);
                    chk(e_to, "out_addr", int'(out_addr), e_oa);
                end
                chk(e_td, "done_valid", int'(done_valid), int'(e_dv));
                if (e_dv) chk(e_td, "done_addr", int'(done_addr), e_da);
            end
            hv = ($urandom % 10) < 3; ht = 4; ha = $urandom % (1 << AW);
            if (hv) begin
                r = $urandom % 10;
                if (r < 6) begin
                    pick = -1;
                    for (int k = 0; k < NL; k++) begin
                        int j;
                        j = (k + c) % NL;
                        if (pick < 0 && m_st[j] == 4) pick = j;
                    end
                    if (pick >= 0) begin
                        ha = m_tag[pick] * NL + pick;
                        if (m_pwb[pick]) ht = 3;
                        else if (m_pst[pick]) ht = 2;
                        else ht = $urandom % 2;
                    end
                end else if (r == 8) ht = $urandom % 3;   // stray fill (R10 when not pending)
                else if (r == 9) ht = 3;                 // stray writeback ack
            end
            rv = ($urandom % 10) < 7; rs = $urandom % 2; ra = $urandom % (1 << AW);
            host_valid = hv; host_type = 3'(ht); host_addr = AW'(ha);
            req_valid = rv; req_store = rs; req_addr = AW'(ra);
            model_step(hv, ht, ha, rv, rs, ra);
            #1;
            chk("R9", "req_ready", int'(req_ready), int'(e_rdy));
        end
        @(negedge clk);
        chk(e_to, "out_valid final", int'(out_valid), int'(e_ov));
        chk(e_td, "done_valid final", int'(done_valid), int'(e_dv));
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule